// File: doc/BRIEF.md
# GPIO Unit with Interrupt Cause Logic

A general-purpose I/O block for a bank of pins, accessed through a small word-addressed register interface. Software sets a direction bit per pin. Pins configured as outputs drive the value held in an output register, and that value can be made to flash by enabling blinking on the pin. Pins configured as inputs pass through a two-stage synchronizer. A per-pin polarity bit then inverts the pin or leaves it as it is. The result is both the readable input value and the source for interrupts.

Each pin can raise an interrupt in two ways. The first is level-sensitive: the current input value, gated by a level mask. The second is edge-triggered: a latched rising-edge flag, gated by an edge mask. Because polarity sits ahead of both paths, setting a pin's polarity bit turns "rising" into "falling" and "high" into "low". The per-pin interrupts are OR-combined in groups of consecutive pins to form the group interrupt outputs.

A free-running timer toggles a shared blink phase every `BLINK_HALF` cycles. Every pin that has blinking enabled XORs this phase into its driven value.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every register reads 0, every pin is an output (`pin_oe_o` all ones) driving 0, and all group interrupts are 0.
- R2: A direction bit of 1 makes the pin an input (`pin_oe_o` bit 0, `pin_o` bit 0). A direction bit of 0 makes it an output whose `pin_o` bit is the output-register bit, when its blink bit is 0.
- R3: The input-value register reads the pin after a two-flop synchronizer, XORed with its polarity bit (1 inverts).
- R4: The input-value register is read-only: a write to word index 4 changes nothing.
- R5: The level source of a pin is its input value AND its level-mask bit. It follows the input and is not latched.
- R6: A 0-to-1 change of a pin's input value sets its edge-cause bit, which stays set until cleared. With polarity 1 this catches a falling pin.
- R7: An edge-cause bit raises an interrupt only while its edge-mask bit is 1.
- R8: Writing the edge-cause register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R9: If a new edge arrives in the same cycle as a clearing write to that bit, the bit ends up set.
- R10: Group output g is the OR of the per-pin interrupts (level source OR masked edge cause) of pins GRP_SIZE*g to GRP_SIZE*g+GRP_SIZE-1.
- R11: An output pin with its blink bit set drives the output bit XOR a shared phase. The phase toggles every BLINK_HALF clock cycles.
- R12: A read request (`req_i`=1, `we_i`=0) returns the selected register on `rdata_o` after the next clock edge. `rdata_o` holds its value otherwise. The word indices are 0 output, 1 direction, 2 blink enable, 3 polarity, 4 input value, 5 edge cause, 6 edge mask and 7 level mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register word index |
| wdata_i | input | N_PINS | Write data |
| rdata_o | output | N_PINS | Registered read data |
| pin_i | input | N_PINS | Pin input values (asynchronous) |
| pin_o | output | N_PINS | Pin output values |
| pin_oe_o | output | N_PINS | Pin output enables |
| grp_irq_o | output | N_PINS/GRP_SIZE | Group interrupt outputs |

## Verification
The checker tests these properties on every cycle:
- Cause bits hold until a clearing write.
- A write clears exactly the bits given as zero, unless an edge arrives in the same cycle.
- A concurrent edge always sets its bit.
- The groups stay quiet while both masks are zero.
- Read data holds between reads.
- Non-blinking outputs change only after a write.

Only the bench scenarios can show the absolute values:
- The polarity-inverted input value after synchronizer latency.
- Falling-edge capture through polarity.
- The mapping of group outputs to pins.
- The blink half-period, measured in cycles between toggles.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    REG_OUT   = 3'd0,
    REG_DIR   = 3'd1,
    REG_BLINK = 3'd2,
    REG_POL   = 3'd3,
    REG_DIN   = 3'd4,
    REG_CAUSE = 3'd5,
    REG_EMASK = 3'd6,
    REG_LMASK = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_blink_timer.sv
module gpio_blink_timer #(
  parameter int HALF = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause #(
  parameter int N        = 32,
  parameter int GRP_SIZE = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N-1:0]          din_i,
  input  logic                  clr_en_i,
  input  logic [N-1:0]          keep_i,
  input  logic [N-1:0]          emask_i,
  input  logic [N-1:0]          lmask_i,
  output logic [N-1:0]          cause_o,
  output logic [N-1:0]          rise_o,
  output logic [N/GRP_SIZE-1:0] grp_o
);
  localparam int N_GRP = N / GRP_SIZE;

  logic [N-1:0] prev_q, cause_q, pin_irq;

  assign rise_o = din_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q  <= din_i;
      // a new edge overrides a concurrent clear
      cause_q <= (clr_en_i ? (cause_q & keep_i) : cause_q) | rise_o;
    end
  end

  assign pin_irq = (din_i & lmask_i) | (cause_q & emask_i);
  assign cause_o = cause_q;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign grp_o[g] = |pin_irq[g*GRP_SIZE +: GRP_SIZE];
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS     = 32,
  parameter int GRP_SIZE   = 8,
  parameter int BLINK_HALF = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [2:0]                 addr_i,
  input  logic [N_PINS-1:0]          wdata_i,
  output logic [N_PINS-1:0]          rdata_o,
  input  logic [N_PINS-1:0]          pin_i,
  output logic [N_PINS-1:0]          pin_o,
  output logic [N_PINS-1:0]          pin_oe_o,
  output logic [N_PINS/GRP_SIZE-1:0] grp_irq_o
);
  logic [N_PINS-1:0] out_q, dir_q, blink_q, pol_q, emask_q, lmask_q;
  logic [N_PINS-1:0] pin_sync, din, edge_cause, rise, rd_mux, rdata_q;
  logic              phase, wr;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(addr_i);
  assign wr  = req_i & we_i;

  gpio_sync #(.W(N_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  assign din = pin_sync ^ pol_q;

  gpio_irq_cause #(.N(N_PINS), .GRP_SIZE(GRP_SIZE)) u_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .din_i   (din),
    .clr_en_i(wr && (sel == REG_CAUSE)),
    .keep_i  (wdata_i),
    .emask_i (emask_q),
    .lmask_i (lmask_q),
    .cause_o (edge_cause),
    .rise_o  (rise),
    .grp_o   (grp_irq_o)
  );

  gpio_blink_timer #(.HALF(BLINK_HALF)) u_blink (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(phase)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      dir_q   <= '0;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else if (wr) begin
      case (sel)
        REG_OUT:   out_q   <= wdata_i;
        REG_DIR:   dir_q   <= wdata_i;
        REG_BLINK: blink_q <= wdata_i;
        REG_POL:   pol_q   <= wdata_i;
        REG_EMASK: emask_q <= wdata_i;
        REG_LMASK: lmask_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      REG_OUT:   rd_mux = out_q;
      REG_DIR:   rd_mux = dir_q;
      REG_BLINK: rd_mux = blink_q;
      REG_POL:   rd_mux = pol_q;
      REG_DIN:   rd_mux = din;
      REG_CAUSE: rd_mux = edge_cause;
      REG_EMASK: rd_mux = emask_q;
      default:   rd_mux = lmask_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_mux;
  end

  assign rdata_o  = rdata_q;
  assign pin_oe_o = ~dir_q;
  assign pin_o    = (out_q ^ (blink_q & {N_PINS{phase}})) & ~dir_q;
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int N_GRP  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [2:0]        addr_i,
  input logic [N_PINS-1:0] wdata_i,
  input logic [N_PINS-1:0] rdata_o,
  input logic [N_PINS-1:0] pin_o,
  input logic [N_PINS-1:0] blink_q,
  input logic [N_PINS-1:0] edge_cause,
  input logic [N_PINS-1:0] rise,
  input logic [N_PINS-1:0] emask_q,
  input logic [N_PINS-1:0] lmask_q,
  input logic [N_GRP-1:0]  grp_irq_o
);
  logic wr_cause;
  assign wr_cause = req_i && we_i && (addr_i == REG_CAUSE);

  // R6, R8: cause bits survive when no clearing write
  p_cause_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cause |=> ((edge_cause & $past(edge_cause)) == $past(edge_cause)));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cause |=> ((edge_cause & ~$past(wdata_i) & ~$past(rise)) == '0));

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((edge_cause & $past(rise)) == $past(rise)));

  p_quiet_groups_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lmask_q == '0 && emask_q == '0) |-> (grp_irq_o == '0));

  p_rdata_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  p_steady_out_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(req_i && we_i) && blink_q == '0) |=> $stable(pin_o));
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(
  .N_PINS(N_PINS),
  .N_GRP (N_PINS / GRP_SIZE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pin_o     (pin_o),
  .blink_q   (blink_q),
  .edge_cause(edge_cause),
  .rise      (rise),
  .emask_q   (emask_q),
  .lmask_q   (lmask_q),
  .grp_irq_o (grp_irq_o)
);

// File: tb/sim_gpio_irq_unit.sv
`timescale 1ns/1ps
module sim_gpio_irq_unit;
  localparam int N  = 32;
  localparam int BH = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [2:0]    addr_i = '0;
  logic [N-1:0]  wdata_i = '0, pin_i = '0;
  logic [N-1:0]  rdata_o, pin_o, pin_oe_o;
  logic [3:0]    grp_irq_o;

  int errors = 0;
  int checks = 0;

  logic [N-1:0] exp_q[$];
  string        tag_q[$];

  gpio_irq_unit #(.N_PINS(N), .GRP_SIZE(8), .BLINK_HALF(BH)) u0 (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .pin_i, .pin_o, .pin_oe_o, .grp_irq_o
  );

  always #2 clk_i = ~clk_i;

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when the design returns it
  always @(posedge clk_i) begin
    if (req_i && !we_i) begin
      #1;
      if (exp_q.size() != 0) check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
    end
  end

  // driver tasks start and end at a negedge
  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [N-1:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    int t0, t1;
    logic p0;
    idle(3);
    rst_ni = 1'b1;
    idle(2);

    // R1 reset state
    for (int i = 0; i < 8; i++) rd(3'(i), '0, "R1 reset register");
    check("R1 oe", pin_oe_o, '1);
    check("R1 pin_o", pin_o, '0);
    check("R1 grp", {28'd0, grp_irq_o}, '0);

    // R2 direction and output, R12 readback
    wr(3'd0, 32'hA5A5_5A5A);
    wr(3'd1, 32'hFFFF_0000);
    check("R2 oe", pin_oe_o, 32'h0000_FFFF);
    check("R2 pin_o", pin_o, 32'h0000_5A5A);
    rd(3'd0, 32'hA5A5_5A5A, "R12 out readback");
    rd(3'd1, 32'hFFFF_0000, "R12 dir readback");

    // R3 input value with polarity
    wr(3'd1, '1);
    check("R2 input pins", pin_o, '0);
    pin_i = 32'h1234_5678;
    idle(4);
    wr(3'd3, 32'h0000_FFFF);
    idle(3);
    rd(3'd4, 32'h1234_5678 ^ 32'h0000_FFFF, "R3 din polarity");
    wr(3'd4, '1);
    rd(3'd4, 32'h1234_5678 ^ 32'h0000_FFFF, "R4 din read-only");

    // clean state
    wr(3'd3, '0);
    pin_i = '0;
    idle(4);
    wr(3'd5, '0);
    rd(3'd5, '0, "R8 clear all");

    // R5 level, R10 grouping
    wr(3'd7, 32'h0000_0100);
    pin_i = 32'h0000_0100;
    idle(3);
    check("R5 level grp", {28'd0, grp_irq_o}, 32'h2);
    pin_i = '0;
    idle(3);
    check("R5 level not latched", {28'd0, grp_irq_o}, 32'h0);
    wr(3'd7, 32'h8000_0001);
    pin_i = 32'h8000_0001;
    idle(3);
    check("R10 group map", {28'd0, grp_irq_o}, 32'h9);
    pin_i = '0;
    idle(3);
    wr(3'd7, '0);

    // R6 rising edge latched, R7 mask, R8 write semantics
    wr(3'd5, '0);
    pin_i = 32'h0010_0000; idle(4);
    pin_i = '0;            idle(4);
    rd(3'd5, 32'h0010_0000, "R6 edge latched");
    check("R7 masked edge", {28'd0, grp_irq_o}, 32'h0);
    wr(3'd6, 32'h0010_0000);
    check("R7 unmasked edge", {28'd0, grp_irq_o}, 32'h4);
    wr(3'd5, '1);
    rd(3'd5, 32'h0010_0000, "R8 write one keeps");
    wr(3'd5, 32'hFFEF_FFFF);
    rd(3'd5, '0, "R8 write zero clears");
    check("R7 cleared grp", {28'd0, grp_irq_o}, 32'h0);

    // R6 falling edge via polarity
    pin_i = 32'h0800_0000; idle(4);
    wr(3'd3, 32'h0800_0000); idle(4);
    wr(3'd5, '0);
    rd(3'd5, '0, "R6 pre-fall clear");
    pin_i = '0; idle(4);
    rd(3'd5, 32'h0800_0000, "R6 falling via polarity");
    rd(3'd4, 32'h0800_0000, "R3 inverted low pin");
    wr(3'd3, '0); idle(3);
    wr(3'd5, '0);

    // R9 set wins over concurrent clear
    pin_i = 32'h0000_0008;
    idle(2);
    wr(3'd5, '0);
    rd(3'd5, 32'h0000_0008, "R9 set wins");
    wr(3'd6, '1);
    check("R10 edge group 0", {28'd0, grp_irq_o}, 32'h1);
    wr(3'd5, '0);
    rd(3'd5, '0, "R8 clear after set");
    check("R10 grp clear", {28'd0, grp_irq_o}, 32'h0);
    pin_i = '0;

    // R11 blink
    wr(3'd1, '0);
    wr(3'd0, 32'h2);
    wr(3'd2, 32'h3);
    p0 = pin_o[0];
    for (int i = 0; i < 100 && pin_o[0] == p0; i++) @(negedge clk_i);
    check("R11 xor with out", {31'd0, pin_o[1]}, {31'd0, ~pin_o[0]});
    check("R11 others low", pin_o & 32'hFFFF_FFFC, '0);
    for (int k = 0; k < 2; k++) begin
      p0 = pin_o[0]; t0 = 0;
      for (int i = 0; i < 100 && pin_o[0] == p0; i++) begin
        @(negedge clk_i); t0++;
      end
      t1 = BH;
      check("R11 half period", 32'(t0), 32'(t1));
    end

    idle(2);
    summary();
  end
endmodule